// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on a simple peripheral bus and drives page-erase and word-program operations on an embedded flash array. Software uses three registers. The address register sets the target page and word. The control register starts an erase, a write sequence, or both, and shows busy, buffer-full and abort status. The data register feeds words to the programmer one at a time.

On the flash side the block drives a one-cycle erase strobe with the page number, and a one-cycle program strobe with a word address and data. It then waits for a done pulse. A per-page lock vector and an information-page access rule decide whether an operation runs or is aborted.

A write sequence stays open while software keeps supplying words. Each programmed word advances the address by one. The sequence closes on its own once no word arrives within a parameterised number of cycles.

Top module: `flash_seq_top`

## Requirements
- R1: Writing the control register (offset 0x0) with bit 0 set starts a page erase. One erase strobe is issued for page = address bits [16:9]. Bit 0 and busy (bit 4) read 1 until the flash done pulse, then read 0.
- R2: While busy, any control-register write is ignored. It starts no operation and changes no control bit.
- R3: When bits 0 and 1 are set in the same write, the erase strobe is issued and completes before the first program strobe of the write sequence.
- R4: A data-register write (offset 0x8) is accepted only while a write sequence waits for data, i.e. bit 1 = 1 and full (bit 5) = 0. Acceptance sets full. Full clears when the word is programmed, and it is 0 whenever busy is 0. Data written at any other time is never programmed.
- R5: An erase, or a write of a word, to a locked page sets abort (bit 6) and issues no strobe. Starting a new erase or write clears abort.
- R6: A write sequence with no data word for TIMEOUT cycles ends with busy = 0 and abort unchanged from its cleared start value, even on a locked page. With erase+write requested together, abort shows the write's outcome.
- R7: The address register (offset 0x4) takes a byte address and reads back bits [18:2] of it, a 17-bit word address. Higher bits wrap away. Writes are ignored while busy.
- R8: After each programmed word the word address increments by one, so consecutive words go to consecutive locations.
- R9: Control bit 2 selects the information page, and the space output follows it. In that space the lock vector is not used. An operation is allowed only when bit 3 (upper-page access) is 1, and otherwise it aborts.
- R10: After reset all readable registers are 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | Write (1) or read (0) |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on bus_addr_i |
| page_lock_i | input | 256 | Lock flag per main-array page |
| erase_stb_o | output | 1 | One-cycle erase request |
| prog_stb_o | output | 1 | One-cycle program request |
| flash_page_o | output | 8 | Page number of the current address |
| flash_addr_o | output | 17 | Word address for programming |
| flash_data_o | output | 32 | Word to program |
| flash_space_o | output | 1 | 1 targets the information page |
| flash_done_i | input | 1 | Completion pulse from the flash |

## Verification
The bench builds the block with TIMEOUT set to 8 and keeps the default 17-bit address and 256 pages. A short timeout lets idle write sequences, and the gap between words, run to expiry within a few dozen cycles. The full address width means one bus write with a bit above bit 18 shows the wrap. A bench flash model answers every strobe three cycles later. That leaves room to issue ignored control, address and data writes while an operation is in flight.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ERASE, S_EWAIT, S_WDATA, S_WPROG, S_WWAIT
  } seq_state_e;

  localparam logic [1:0] REG_CTL = 2'd0;
  localparam logic [1:0] REG_ADR = 2'd1;
  localparam logic [1:0] REG_DAT = 2'd2;

  localparam int unsigned B_ERASE = 0;
  localparam int unsigned B_WRITE = 1;
  localparam int unsigned B_INFO  = 2;
  localparam int unsigned B_UPPER = 3;
  localparam int unsigned B_BUSY  = 4;
  localparam int unsigned B_FULL  = 5;
  localparam int unsigned B_ABORT = 6;
endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else           cnt_q <= cnt_q + TW'(1);
  end

  assign expire_o = en_i && (cnt_q == TW'(TIMEOUT - 1));

  p_tmr_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/fseq_regs.sv
module fseq_regs
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        reg_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              inc_i,
  input  logic              data_ld_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              info_sel_o,
  output logic              upper_ok_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic info_q, upper_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      info_q  <= 1'b0;
      upper_q <= 1'b0;
    end else if (inc_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end else if (wr_i && !busy_i) begin
      if (reg_i == REG_ADR) addr_q <= wdata_i[ADDR_W+1:2];
      if (reg_i == REG_CTL) begin
        info_q  <= wdata_i[B_INFO];
        upper_q <= wdata_i[B_UPPER];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (data_ld_i) data_q <= wdata_i[DATA_W-1:0];
  end

  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign info_sel_o = info_q;
  assign upper_ok_o = upper_q;

  // address frozen during an operation except for word advance
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !inc_i |=> $stable(addr_q));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic go_erase_i,
  input  logic go_write_i,
  input  logic dat_wr_i,
  input  logic locked_i,
  input  logic done_i,
  input  logic expire_i,
  output logic erase_o,
  output logic write_o,
  output logic busy_o,
  output logic full_o,
  output logic abort_o,
  output logic erase_stb_o,
  output logic prog_stb_o,
  output logic data_ld_o,
  output logic addr_inc_o,
  output logic tmr_en_o
);
  seq_state_e state_q;
  logic erase_q, write_q, full_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      erase_q <= 1'b0;
      write_q <= 1'b0;
      full_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (ctl_wr_i && (go_erase_i || go_write_i)) begin
          erase_q <= go_erase_i;
          write_q <= go_write_i;
          abort_q <= 1'b0;
          state_q <= go_erase_i ? S_ERASE : S_WDATA;
        end
        S_ERASE: if (locked_i) begin
          erase_q <= 1'b0;
          abort_q <= !write_q;  // a following write restarts status
          state_q <= write_q ? S_WDATA : S_IDLE;
        end else begin
          state_q <= S_EWAIT;
        end
        S_EWAIT: if (done_i) begin
          erase_q <= 1'b0;
          state_q <= write_q ? S_WDATA : S_IDLE;
        end
        S_WDATA: if (dat_wr_i) begin
          full_q  <= 1'b1;
          state_q <= S_WPROG;
        end else if (expire_i) begin
          write_q <= 1'b0;
          state_q <= S_IDLE;
        end
        S_WPROG: if (locked_i) begin
          abort_q <= 1'b1;
          write_q <= 1'b0;
          full_q  <= 1'b0;
          state_q <= S_IDLE;
        end else begin
          state_q <= S_WWAIT;
        end
        S_WWAIT: if (done_i) begin
          full_q  <= 1'b0;
          state_q <= S_WDATA;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign erase_o     = erase_q;
  assign write_o     = write_q;
  assign busy_o      = erase_q | write_q;
  assign full_o      = full_q;
  assign abort_o     = abort_q;
  assign erase_stb_o = (state_q == S_ERASE) && !locked_i;
  assign prog_stb_o  = (state_q == S_WPROG) && !locked_i;
  assign data_ld_o   = (state_q == S_WDATA) && dat_wr_i;
  assign addr_inc_o  = (state_q == S_WWAIT) && done_i;
  assign tmr_en_o    = (state_q == S_WDATA);

  p_full_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !full_q);
  p_erase_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |-> !erase_q);
  p_abort_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !abort_q);
  p_busy_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i && !expire_i && !locked_i |=> busy_o);
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned PAGE_BITS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TIMEOUT   = 16,
  localparam int unsigned PAGES    = 1 << PAGE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [3:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [PAGES-1:0]     page_lock_i,
  output logic                 erase_stb_o,
  output logic                 prog_stb_o,
  output logic [PAGE_BITS-1:0] flash_page_o,
  output logic [ADDR_W-1:0]    flash_addr_o,
  output logic [DATA_W-1:0]    flash_data_o,
  output logic                 flash_space_o,
  input  logic                 flash_done_i
);
  logic [1:0] reg_sel;
  logic wr, ctl_wr, dat_wr;
  logic erase, write, busy, full, abort;
  logic data_ld, addr_inc, tmr_en, expire, locked;
  logic info_sel, upper_ok;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_BITS-1:0] page;

  assign reg_sel = bus_addr_i[3:2];
  assign wr      = bus_sel_i && bus_wr_i;
  assign ctl_wr  = wr && (reg_sel == REG_CTL);
  assign dat_wr  = wr && (reg_sel == REG_DAT);
  assign page    = addr[ADDR_W-1 -: PAGE_BITS];
  // info space is gated by the access bit, main space by the lock vector
  assign locked  = info_sel ? !upper_ok : page_lock_i[page];

  fseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i       (wr),
    .reg_i      (reg_sel),
    .wdata_i    (bus_wdata_i),
    .busy_i     (busy),
    .inc_i      (addr_inc),
    .data_ld_i  (data_ld),
    .addr_o     (addr),
    .data_o     (flash_data_o),
    .info_sel_o (info_sel),
    .upper_ok_o (upper_ok)
  );

  fseq_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .ctl_wr_i    (ctl_wr),
    .go_erase_i  (bus_wdata_i[B_ERASE]),
    .go_write_i  (bus_wdata_i[B_WRITE]),
    .dat_wr_i    (dat_wr),
    .locked_i    (locked),
    .done_i      (flash_done_i),
    .expire_i    (expire),
    .erase_o     (erase),
    .write_o     (write),
    .busy_o      (busy),
    .full_o      (full),
    .abort_o     (abort),
    .erase_stb_o (erase_stb_o),
    .prog_stb_o  (prog_stb_o),
    .data_ld_o   (data_ld),
    .addr_inc_o  (addr_inc),
    .tmr_en_o    (tmr_en)
  );

  fseq_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i, .rst_ni,
    .en_i     (tmr_en),
    .expire_o (expire)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_sel)
      REG_CTL: begin
        bus_rdata_o[B_ERASE] = erase;
        bus_rdata_o[B_WRITE] = write;
        bus_rdata_o[B_INFO]  = info_sel;
        bus_rdata_o[B_UPPER] = upper_ok;
        bus_rdata_o[B_BUSY]  = busy;
        bus_rdata_o[B_FULL]  = full;
        bus_rdata_o[B_ABORT] = abort;
      end
      REG_ADR: bus_rdata_o[ADDR_W-1:0] = addr;
      default: bus_rdata_o = '0;
    endcase
  end

  assign flash_page_o  = page;
  assign flash_addr_o  = addr;
  assign flash_space_o = info_sel;

  p_one_stb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_stb_o |=> !erase_stb_o);
  p_lock_nostb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!info_sel && page_lock_i[page]) |-> !(erase_stb_o || prog_stb_o));
endmodule

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int LAT = 3;
  localparam logic [3:0] A_CTL = 4'h0, A_ADR = 4'h4, A_DAT = 4'h8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [255:0] lock = '0;
  logic erase_stb, prog_stb, space, done = 1'b0;
  logic [7:0] fpage;
  logic [16:0] faddr;
  logic [31:0] fdata;

  int checks = 0, fails = 0;
  int n_erase = 0, n_prog = 0, lat = 0, cyc = 0;
  int erase_cyc = 0, prog_cyc = 0;
  logic [7:0]  e_page = '0;
  logic        e_space = 1'b0;
  logic [16:0] p_addr [0:15];
  logic [31:0] p_data [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_top #(.TIMEOUT(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .page_lock_i(lock), .erase_stb_o(erase_stb), .prog_stb_o(prog_stb),
    .flash_page_o(fpage), .flash_addr_o(faddr), .flash_data_o(fdata),
    .flash_space_o(space), .flash_done_i(done)
  );

  // flash model: done pulse LAT cycles after any strobe
  always @(posedge clk) begin
    cyc <= cyc + 1;
    done <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) done <= 1'b1;
    end
    if (erase_stb) begin
      lat <= LAT; n_erase <= n_erase + 1;
      e_page <= fpage; e_space <= space; erase_cyc <= cyc;
    end
    if (prog_stb) begin
      lat <= LAT; prog_cyc <= cyc;
      if (n_prog < 16) begin p_addr[n_prog] <= faddr; p_data[n_prog] <= fdata; end
      n_prog <= n_prog + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_CTL, v);
      if (!v[4]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_not_full();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      bus_rd(A_CTL, v);
      if (!v[5]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(A_CTL, v); chk("R10 ctl reset", v, 32'h0);
    bus_rd(A_ADR, v); chk("R10 addr reset", v, 32'h0);
    chk("R10 no strobe", {30'b0, erase_stb, prog_stb}, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    bus_wr(A_ADR, 32'h0001_2344);
    bus_rd(A_ADR, v); chk("R7 byte addr shifted", v, 32'h48D1);
    bus_wr(A_ADR, 32'h0008_0004);
    bus_rd(A_ADR, v); chk("R7 wrap", v, 32'h1);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    bus_wr(A_ADR, 32'h2800);          // page 5
    bus_wr(A_CTL, 32'h1);
    bus_rd(A_CTL, v); chk("R1 busy during erase", v, 32'h11);
    bus_wr(A_CTL, 32'h2);             // ignored while busy
    bus_wr(A_ADR, 32'h4000);          // ignored while busy
    bus_rd(A_ADR, v); chk("R7 addr write ignored busy", v, 32'hA00);
    wait_idle();
    chk("R1 one erase strobe", n_erase, 1);
    chk("R1 erase page", e_page, 8'd5);
    bus_rd(A_CTL, v); chk("R1 bits clear after done", v, 32'h0);
    chk("R2 ignored go started nothing", n_prog, 0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    bus_wr(A_DAT, 32'hDEAD0000);      // idle: ignored
    bus_wr(A_ADR, 32'h400);           // word 0x100
    bus_wr(A_CTL, 32'h2);
    bus_rd(A_CTL, v); chk("R4 waiting for data", v, 32'h12);
    bus_wr(A_DAT, 32'hA5A5_0001);
    bus_rd(A_CTL, v); chk("R4 full after accept", v, 32'h32);
    bus_wr(A_DAT, 32'hBAD0_BAD0);     // full: ignored
    wait_not_full();
    bus_wr(A_DAT, 32'h5A5A_0002);
    wait_idle();
    chk("R4 only accepted words programmed", n_prog, 2);
    chk("R4 first word data", p_data[0], 32'hA5A5_0001);
    chk("R8 first addr", p_addr[0], 17'h100);
    chk("R8 second addr", p_addr[1], 17'h101);
    chk("R8 second data", p_data[1], 32'h5A5A_0002);
    bus_rd(A_ADR, v); chk("R8 addr after seq", v, 32'h102);
    bus_rd(A_CTL, v); chk("R6 timeout end no abort", v, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    int np, ne;
    lock[3] = 1'b1;
    bus_wr(A_ADR, 32'h3 << 11);       // page 3
    np = n_prog; ne = n_erase;
    bus_wr(A_CTL, 32'h2);
    bus_wr(A_DAT, 32'h1111_1111);
    wait_idle();
    bus_rd(A_CTL, v); chk("R5 write locked abort", v, 32'h40);
    chk("R5 no prog strobe", n_prog, np);
    bus_wr(A_CTL, 32'h2);
    bus_rd(A_CTL, v); chk("R5 abort cleared at start", v[6], 1'b0);
    wait_idle();
    bus_rd(A_CTL, v); chk("R6 timeout locked no abort", v, 32'h0);
    bus_wr(A_CTL, 32'h1);
    wait_idle();
    bus_rd(A_CTL, v); chk("R5 erase locked abort", v, 32'h40);
    chk("R5 no erase strobe", n_erase, ne);
    bus_wr(A_CTL, 32'h3);
    wait_idle();
    bus_rd(A_CTL, v); chk("R6 combined abort follows write", v, 32'h0);
    lock[3] = 1'b0;
  endtask

  task automatic t_combined();
    logic [31:0] v;
    int np, ne;
    np = n_prog; ne = n_erase;
    bus_wr(A_ADR, 32'h7 << 11);       // page 7
    bus_wr(A_CTL, 32'h3);
    bus_rd(A_CTL, v); chk("R3 both bits set", v, 32'h13);
    bus_wr(A_DAT, 32'hCCCC_CCCC);     // during erase: ignored
    for (int i = 0; i < 20; i++) begin
      bus_rd(A_CTL, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    bus_wr(A_DAT, 32'h7777_0007);
    wait_idle();
    chk("R3 erase issued", n_erase, ne + 1);
    chk("R3 prog issued", n_prog, np + 1);
    chk("R3 erase before prog", erase_cyc < prog_cyc, 1'b1);
    chk("R4 erase-phase data dropped", p_data[np], 32'h7777_0007);
    chk("R3 prog addr", p_addr[np], 17'h7 << 9);
  endtask

  task automatic t_info();
    logic [31:0] v;
    int ne;
    ne = n_erase;
    lock[2] = 1'b1;
    bus_wr(A_ADR, 32'h2 << 11);       // page 2 locked in main space
    bus_wr(A_CTL, 32'h5);             // info, no upper access
    wait_idle();
    bus_rd(A_CTL, v); chk("R9 info denied abort", v, 32'h44);
    chk("R9 no strobe", n_erase, ne);
    bus_wr(A_CTL, 32'hD);             // info + upper access
    wait_idle();
    bus_rd(A_CTL, v); chk("R9 info allowed", v, 32'hC);
    chk("R9 erase strobe", n_erase, ne + 1);
    chk("R9 space out", e_space, 1'b1);
    lock[2] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_erase();
    t_write();
    t_lock();
    t_combined();
    t_info();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule